// File: doc/BRIEF.md
# Multi-Cycle Instruction Fetch Sequencer

This block fetches one instruction word at a time by moving it through a chain of registers, with one transfer on each clock edge. A program counter holds the address of the next word to fetch. At the start of a fetch that address is copied into a dedicated address register, and the memory read port is driven only from that register. The returned word is first held in a buffer register and is then moved into the instruction register. The instruction register feeds the decoder. No register is read and written by the same transfer.

After the instruction register is loaded, the sequencer raises a one-cycle valid strobe and waits in an execute state. It leaves that state when the executing logic signals completion. While it waits, a new program counter value may be loaded so that jumps can be modelled. The `run` level decides whether completion starts the next fetch straight away or returns the block to idle.

The decoder port has no back-pressure. `instr_valid` is a single-cycle strobe that cannot be stalled, and `instr` holds its value until the next fetch reloads the instruction register. Flow control comes from `exec_done` alone: no new fetch begins until it is sampled high in the execute state. The memory port also has no stall. It must return the word one cycle after `mem_rd_en`.

Top module: `ifetch_seq`

## Requirements
- R1: A synchronous reset makes the following changes:
  - the program counter is set to `RESET_ADDR`;
  - the address, buffer and instruction registers are cleared, so `mem_addr` and `instr` read 0;
  - `mem_rd_en` and `instr_valid` go low;
  - the block goes idle.
- R2: When `run` is high at an edge while the block is idle, that edge copies the program counter into the address register. In the next cycle `mem_rd_en` is high for exactly one cycle and `mem_addr` carries that address. `mem_addr` comes only from the address register and does not change until the next fetch starts.
- R3: Memory is a synchronous read with a latency of one cycle. The word must be on `mem_rdata` in the cycle after `mem_rd_en`, and the buffer register captures it at the end of that cycle. A value present in any other cycle is not captured.
- R4: The buffer register is copied into `instr` at the following edge, which is the third edge after the address load. `instr_valid` is high for exactly the first cycle in which `instr` shows the new word. With `RESET_ADDR` = 50, the first fetch reads address 50 and delivers the word at address 50.
- R5: The program counter increases by one at the edge that ends the read-request cycle. It wraps from all ones to zero.
- R6: After a fetch the block waits in the execute state and issues no read until `exec_done` is sampled high. At that edge, `run` high starts the next fetch, and this can happen as early as the `instr_valid` cycle. `run` low returns the block to idle.
- R7: `load_pc` high in the execute state replaces the program counter with `load_pc_addr`. If it comes in the same cycle as `exec_done`, the fetch that starts at that edge uses the loaded address.
- R8: `load_pc` and `exec_done` have no effect while the block is idle or in the middle of a fetch.
- R9: `instr` stays stable throughout the execute state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Level: allow fetching |
| exec_done | input | 1 | Executing logic has finished the current instruction |
| load_pc | input | 1 | Load a new program counter value (execute state only) |
| load_pc_addr | input | ADDR_W | Value loaded by `load_pc` |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory read address, from the address register |
| mem_rdata | input | DATA_W | Read data, valid one cycle after `mem_rd_en` |
| instr_valid | output | 1 | One-cycle strobe: new instruction on `instr` |
| instr | output | DATA_W | Instruction register contents, to the decoder |

## Verification
The memory model returns a filler word in every cycle except the one right after a read request. A buffer that captures a cycle early or late therefore delivers the filler instead of the addressed word. The bench raises completion during the `instr_valid` cycle, where a design that ignored completion in that cycle would hang in execute. It also raises completion together with a program counter load, where a design that sampled the counter before the load would fetch the sequential address. Further cases cover the wrap from the top address to zero and completion or loads issued while idle; mishandling these shows up as a wrong next fetch address or a spurious read.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_CAPT,
    ST_MOVE,
    ST_EXEC
  } fetch_state_e;

  typedef struct packed {
    logic ld_mar;
    logic inc_pc;
    logic ld_mbr;
    logic ld_ir;
    logic jump;
  } xfer_ctl_t;

endpackage

// File: rtl/ifetch_ctrl.sv
module ifetch_ctrl
  import ifetch_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         exec_done,
  input  logic         load_pc,
  output fetch_state_e state,
  output xfer_ctl_t    ctl,
  output logic         mem_rd_en,
  output logic         instr_valid
);

  fetch_state_e state_q, state_d;
  logic         valid_q;
  logic         in_exec;
  logic         begin_fetch;

  assign in_exec     = (state_q == ST_EXEC);
  assign begin_fetch = run && ((state_q == ST_IDLE) || (in_exec && exec_done));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (run) state_d = ST_REQ;
      ST_REQ:  state_d = ST_CAPT;
      ST_CAPT: state_d = ST_MOVE;
      ST_MOVE: state_d = ST_EXEC;
      ST_EXEC: if (exec_done) state_d = run ? ST_REQ : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      valid_q <= (state_q == ST_MOVE);
    end
  end

  // One transfer enable per step; each fires on a distinct edge.
  always_comb begin
    ctl.ld_mar = begin_fetch;
    ctl.inc_pc = (state_q == ST_REQ);
    ctl.ld_mbr = (state_q == ST_CAPT);
    ctl.ld_ir  = (state_q == ST_MOVE);
    ctl.jump   = in_exec && load_pc;
  end

  assign state       = state_q;
  assign mem_rd_en   = (state_q == ST_REQ);
  assign instr_valid = valid_q;

endmodule

// File: rtl/ifetch_pc.sv
module ifetch_pc #(
  parameter int unsigned          ADDR_W     = 8,
  parameter logic [ADDR_W-1:0]    RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              jump,
  input  logic [ADDR_W-1:0] jump_addr,
  input  logic              inc,
  output logic [ADDR_W-1:0] pc_q,
  output logic [ADDR_W-1:0] pc_next
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

  logic [ADDR_W-1:0] pc_r;

  // Value the address register sees on a fetch-start edge: a jump in the
  // same cycle wins over the held count.
  assign pc_next = jump ? jump_addr : pc_r;

  always_ff @(posedge clk) begin
    if (rst)       pc_r <= RESET_ADDR;
    else if (jump) pc_r <= jump_addr;
    else if (inc)  pc_r <= pc_r + STEP;
  end

  assign pc_q = pc_r;

endmodule

// File: rtl/ifetch_xfer.sv
module ifetch_xfer #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_mar,
  input  logic [ADDR_W-1:0] mar_src,
  input  logic              ld_mbr,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              ld_ir,
  output logic [ADDR_W-1:0] mar_q,
  output logic [DATA_W-1:0] mbr_q,
  output logic [DATA_W-1:0] ir_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mar_q <= '0;
      mbr_q <= '0;
      ir_q  <= '0;
    end else begin
      if (ld_mar) mar_q <= mar_src;
      if (ld_mbr) mbr_q <= mem_rdata;
      if (ld_ir)  ir_q  <= mbr_q;
    end
  end

endmodule

// File: rtl/ifetch_seq.sv
module ifetch_seq
  import ifetch_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 8,
  parameter int unsigned       DATA_W     = 16,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              exec_done,
  input  logic              load_pc,
  input  logic [ADDR_W-1:0] load_pc_addr,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              instr_valid,
  output logic [DATA_W-1:0] instr
);

  fetch_state_e      st;
  xfer_ctl_t         ctl;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] pc_next;
  logic [ADDR_W-1:0] mar_q;
  logic [DATA_W-1:0] mbr_q;

  ifetch_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .run         (run),
    .exec_done   (exec_done),
    .load_pc     (load_pc),
    .state       (st),
    .ctl         (ctl),
    .mem_rd_en   (mem_rd_en),
    .instr_valid (instr_valid)
  );

  ifetch_pc #(
    .ADDR_W     (ADDR_W),
    .RESET_ADDR (RESET_ADDR)
  ) u_pc (
    .clk       (clk),
    .rst       (rst),
    .jump      (ctl.jump),
    .jump_addr (load_pc_addr),
    .inc       (ctl.inc_pc),
    .pc_q      (pc_q),
    .pc_next   (pc_next)
  );

  ifetch_xfer #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_xfer (
    .clk       (clk),
    .rst       (rst),
    .ld_mar    (ctl.ld_mar),
    .mar_src   (pc_next),
    .ld_mbr    (ctl.ld_mbr),
    .mem_rdata (mem_rdata),
    .ld_ir     (ctl.ld_ir),
    .mar_q     (mar_q),
    .mbr_q     (mbr_q),
    .ir_q      (instr)
  );

  assign mem_addr = mar_q;

endmodule

// File: rtl/ifetch_seq_chk.sv
module ifetch_seq_chk
  import ifetch_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input fetch_state_e      st,
  input logic [ADDR_W-1:0] pc_q,
  input logic [DATA_W-1:0] mbr_q,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_rdata,
  input logic              instr_valid,
  input logic [DATA_W-1:0] instr,
  input logic              exec_done,
  input logic              run
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

  p_mar_from_pc_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_REQ && $past(st) == ST_IDLE) |-> mem_addr == $past(pc_q));

  p_addr_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CAPT || st == ST_MOVE) |-> $stable(mem_addr));

  p_single_read_r2: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);

  p_mbr_capture_r3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_MOVE) |-> mbr_q == $past(mem_rdata));

  p_ir_from_mbr_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(instr_valid) |-> instr == $past(mbr_q));

  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    instr_valid |=> !instr_valid);

  p_pc_step_r5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CAPT) |-> pc_q == $past(mem_addr) + STEP);

  p_exec_wait_r6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_EXEC && !exec_done) |=> (st == ST_EXEC && !mem_rd_en));

  p_exec_next_r6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_EXEC && exec_done && run) |=> mem_rd_en);

  p_instr_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (st == ST_EXEC && $past(st) == ST_EXEC) |-> $stable(instr));

endmodule

bind ifetch_seq ifetch_seq_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .st          (st),
  .pc_q        (pc_q),
  .mbr_q       (mbr_q),
  .mem_rd_en   (mem_rd_en),
  .mem_addr    (mem_addr),
  .mem_rdata   (mem_rdata),
  .instr_valid (instr_valid),
  .instr       (instr),
  .exec_done   (exec_done),
  .run         (run)
);

// File: tb/tb_ifetch_seq.sv
`timescale 1ns/100ps
module tb_ifetch_seq;

  localparam int AW = 8;
  localparam int DW = 16;
  localparam logic [DW-1:0] FILLER = 16'hBAD0;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          run = 1'b0;
  logic          exec_done = 1'b0;
  logic          load_pc = 1'b0;
  logic [AW-1:0] load_pc_addr = '0;
  logic          mem_rd_en;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata = '0;
  logic          instr_valid;
  logic [DW-1:0] instr;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ifetch_seq #(
    .ADDR_W     (AW),
    .DATA_W     (DW),
    .RESET_ADDR (8'd50)
  ) dut (
    .clk          (clk),
    .rst          (rst),
    .run          (run),
    .exec_done    (exec_done),
    .load_pc      (load_pc),
    .load_pc_addr (load_pc_addr),
    .mem_rd_en    (mem_rd_en),
    .mem_addr     (mem_addr),
    .mem_rdata    (mem_rdata),
    .instr_valid  (instr_valid),
    .instr        (instr)
  );

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return {a ^ 8'h5A, a};
  endfunction

  // Synchronous read, one cycle latency; filler in every other cycle.
  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem_word(mem_addr);
    else           mem_rdata <= FILLER;
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Starts a fetch at the next edge (from idle or execute) and follows it.
  task automatic fetch_check(input logic [AW-1:0] exp, input bit jump, input logic [AW-1:0] jaddr);
    run          = 1'b1;
    exec_done    = 1'b1;
    load_pc      = jump;
    load_pc_addr = jaddr;
    tick();
    exec_done = 1'b0;
    load_pc   = 1'b0;
    chk(mem_rd_en == 1'b1, "R2 read request", 32'(mem_rd_en), 1);
    chk(mem_addr == exp, jump ? "R7 fetch address" : "R2/R5 fetch address", 32'(mem_addr), 32'(exp));
    chk(instr_valid == 1'b0, "R4 valid low during request", 32'(instr_valid), 0);
    tick();
    chk(mem_rd_en == 1'b0, "R2 single read", 32'(mem_rd_en), 0);
    chk(mem_addr == exp, "R2 address held", 32'(mem_addr), 32'(exp));
    tick();
    chk(instr_valid == 1'b0, "R4 valid not early", 32'(instr_valid), 0);
    tick();
    chk(instr_valid == 1'b1, "R4 valid strobe", 32'(instr_valid), 1);
    chk(instr == mem_word(exp), "R3/R4 fetched word", 32'(instr), 32'(mem_word(exp)));
  endtask

  task automatic test_reset();
    rst = 1'b1;
    tick();
    tick();
    chk(mem_rd_en == 1'b0, "R1 no read in reset", 32'(mem_rd_en), 0);
    chk(mem_addr == '0, "R1 address register clear", 32'(mem_addr), 0);
    chk(instr == '0, "R1 instruction register clear", 32'(instr), 0);
    chk(instr_valid == 1'b0, "R1 valid low", 32'(instr_valid), 0);
    rst = 1'b0;
    tick();
    chk(mem_rd_en == 1'b0, "R1 idle after reset", 32'(mem_rd_en), 0);
  endtask

  task automatic test_first_fetch();
    // R4: reset address 50 delivers the word at 50
    fetch_check(8'd50, 1'b0, '0);
  endtask

  task automatic test_exec_wait();
    logic [DW-1:0] held;
    held = instr;
    tick();
    chk(instr_valid == 1'b0, "R4 valid one cycle", 32'(instr_valid), 0);
    for (int i = 0; i < 5; i++) begin
      tick();
      chk(mem_rd_en == 1'b0, "R6 no read while executing", 32'(mem_rd_en), 0);
      chk(instr == held, "R9 instruction held", 32'(instr), 32'(held));
    end
  endtask

  task automatic test_sequential();
    fetch_check(8'd51, 1'b0, '0); // R5 increment
  endtask

  task automatic test_idle_ignore();
    run       = 1'b0;
    exec_done = 1'b1;
    tick();
    exec_done = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk(mem_rd_en == 1'b0, "R6 idle with run low", 32'(mem_rd_en), 0);
    end
    load_pc      = 1'b1;
    load_pc_addr = 8'h10;
    exec_done    = 1'b1;
    tick();
    tick();
    load_pc   = 1'b0;
    exec_done = 1'b0;
    chk(mem_rd_en == 1'b0, "R8 done ignored while idle", 32'(mem_rd_en), 0);
    fetch_check(8'd52, 1'b0, '0); // R8 load ignored: still 52
  endtask

  task automatic test_jump_separate();
    tick();
    load_pc      = 1'b1;
    load_pc_addr = 8'h80;
    tick();
    load_pc = 1'b0;
    tick();
    fetch_check(8'h80, 1'b0, '0); // R7 earlier load
  endtask

  task automatic test_jump_with_done();
    fetch_check(8'h20, 1'b1, 8'h20); // R7 load with done, back to back
  endtask

  task automatic test_wrap();
    fetch_check(8'hFF, 1'b1, 8'hFF);
    fetch_check(8'h00, 1'b0, '0);  // R5 wrap to zero
  endtask

  initial begin
    test_reset();
    test_first_fetch();
    test_exec_wait();
    test_sequential();
    test_idle_ignore();
    test_jump_separate();
    test_jump_with_done();
    test_wrap();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000 && !finished) begin
        finished = 1'b1;
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 5000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

endmodule